// File: doc/BRIEF.md
# Group-Reversing Ping-Pong Stack

This stage sits at the point where a symmetric filter's forward delay chain turns back into its reverse chain. When a decimating filter runs, samples must reach the reverse chain in reversed group order, so the pairs that share a coefficient line up at the pre-adders. The stage holds two last-in-first-out stacks. On every valid sample, one stack takes the incoming value and the other gives up its most recently stored value. The two stacks trade roles whenever an externally generated transfer strobe falls. If the strobe falls once every N clocks, each group of N samples leaves the stage in reverse order.

With reversal turned off, the stage is a plain delay register. It advances one step on every valid sample, and the stacks are not touched. The stack depth is a parameter that bounds the largest group size. A sample that arrives when the writing stack is already full is discarded, and a sticky overflow flag is raised. The flag is cleared only by reset.

Top module: `lifo_reverser`

## Requirements
- R1: Asserting reset drives `dout_o` to 0 and `ovf_o` to 0 and leaves both stacks empty. Stack A is the writer, and the strobe history counts as low.
- R2: With `rev_en_i` = 0, each clock edge that sees `din_vld_i` = 1 loads `din_i` into `dout_o`, giving exactly one cycle of delay.
- R3: With `rev_en_i` = 1, each valid sample is pushed onto the writing stack. In the same edge, `dout_o` takes the value popped from the top of the reading stack, so a group leaves in the reverse of its arrival order.
- R4: The stacks swap roles only on an edge where the strobe was sampled high on the previous edge and is low now. A strobe that stays low, or a rising strobe, causes no swap.
- R5: On the swap edge itself, the incoming sample becomes the first entry of the newly writing stack, which is emptied at that edge. `dout_o` receives the last entry of the group just completed.
- R6: A pop from an empty reading stack yields 0 on `dout_o`.
- R7: A push onto a stack that already holds DEPTH entries is discarded and sets `ovf_o`. `ovf_o` stays at 1 until reset.
- R8: When `din_vld_i` = 0, `dout_o` holds its value and neither stack is pushed or popped.
- R9: A falling strobe while `rev_en_i` = 0 causes no swap. The same stack keeps reading once reversal is turned back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rev_en_i | input | 1 | 1 = group reversal, 0 = plain one-stage delay |
| din_i | input | DW | Sample from the fold-point multiplexer |
| din_vld_i | input | 1 | Sample-valid / advance enable |
| xfer_i | input | 1 | Transfer strobe; its falling edge swaps the stacks |
| dout_o | output | DW | Sample toward the reverse delay chain |
| ovf_o | output | 1 | Sticky flag: a sample was dropped because the stack was full |

## Verification
The swap and the data movement share an edge. When the strobe falls on a valid sample, one clock must empty the new writer, store the new sample as that writer's first entry, and pop the top of the stack that has just become the reader. The bench makes this happen with strobe patterns that fall on valid samples, stay low, and rise. It expects `dout_o` to carry the last sample of the completed group on that edge. A second collision is provoked by filling a stack to DEPTH and then pushing once more while the reading stack is empty. On that edge the bench expects a zero output and the overflow flag to be raised. On the next swap it expects the stored full group to come out intact and the flag to stay set.

// File: rtl/lifo_rev_pkg.sv
package lifo_rev_pkg;
  typedef enum logic {
    STACK_A = 1'b0,
    STACK_B = 1'b1
  } stack_id_e;
endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic prev_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strobe_i;
  end

  assign prev_o = prev_q;
  assign fall_o = prev_q & ~strobe_i;

  // After a detected fall the strobe sits low, so the next edge cannot fall again
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R4
endmodule

// File: rtl/lifo_stack.sv
module lifo_stack #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, base;
  logic [CW-1:0] top_idx;
  logic          wr_ok;

  // count after an optional clear in this same cycle
  assign base    = clr_i ? '0 : cnt_q;
  assign full_o  = (base == FULL_CNT);
  assign wr_ok   = push_i && !full_o;
  assign top_idx = cnt_q - 1'b1;
  assign rdata_o = (cnt_q == '0) ? '0 : mem_q[top_idx[AW-1:0]];

  always_comb begin
    cnt_d = base;
    if (wr_ok)                      cnt_d = base + 1'b1;
    else if (pop_i && base != '0)   cnt_d = base - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[base[AW-1:0]] <= wdata_i;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !push_i) |=> (cnt_q == '0)); // R5
  AST_NO_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R3
endmodule

// File: rtl/lifo_reverser.sv
module lifo_reverser #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rev_en_i,
  input  logic [DW-1:0] din_i,
  input  logic          din_vld_i,
  input  logic          xfer_i,
  output logic [DW-1:0] dout_o,
  output logic          ovf_o
);
  import lifo_rev_pkg::*;

  localparam int NSTK = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n = rst_s2_q & rst_ni;

  logic xfer_prev, xfer_fall, swap;
  strobe_fall_det u_fall (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .strobe_i (xfer_i),
    .prev_o   (xfer_prev),
    .fall_o   (xfer_fall)
  );

  stack_id_e     wsel_q, wsel_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          ovf_q, ovf_d;
  logic          step;
  logic [DW-1:0] stk_rd [NSTK];
  logic          stk_full [NSTK];

  assign swap   = rev_en_i & xfer_fall;
  assign wsel_d = stack_id_e'(wsel_q ^ swap);
  assign step   = rev_en_i & din_vld_i;

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    logic is_wr;
    assign is_wr = (wsel_d == stack_id_e'(g));
    lifo_stack #(.DW(DW), .DEPTH(DEPTH)) u_stk (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .clr_i   (swap && is_wr),
      .push_i  (step && is_wr),
      .pop_i   (step && !is_wr),
      .wdata_i (din_i),
      .rdata_o (stk_rd[g]),
      .full_o  (stk_full[g])
    );
  end

  always_comb begin
    dout_d = dout_q;
    if (din_vld_i) begin
      if (rev_en_i) dout_d = (wsel_d == STACK_A) ? stk_rd[1] : stk_rd[0];
      else          dout_d = din_i;
    end
    ovf_d = ovf_q | (step & ((wsel_d == STACK_A) ? stk_full[0] : stk_full[1]));
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= STACK_A;
      dout_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wsel_q <= wsel_d;
      if (din_vld_i) dout_q <= dout_d;
      ovf_q  <= ovf_d;
    end
  end

  assign dout_o = dout_q;
  assign ovf_o  = ovf_q;

  AST_BYPASS_DELAY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!rev_en_i && din_vld_i) |=> (dout_o == $past(din_i))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !din_vld_i |=> $stable(dout_o)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovf_o |=> ovf_o); // R7
  AST_SWAP_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rev_en_i && xfer_prev && !xfer_i) |=> $stable(wsel_q)); // R4
endmodule

// File: tb/lifo_reverser_test.sv
module lifo_reverser_test;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst_n;
  logic rev_en, din_vld, xfer;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic ovf;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lifo_reverser #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rev_en_i(rev_en), .din_i(din),
    .din_vld_i(din_vld), .xfer_i(xfer), .dout_o(dout), .ovf_o(ovf)
  );

  // fields: tag[4] rev vld xfer din[8] exp_dout[8] exp_ovf
  localparam logic [23:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b1, 1'b0, 8'h11, 8'h11, 1'b0}, // R2 delay
    {4'd8, 1'b0, 1'b0, 1'b0, 8'h22, 8'h11, 1'b0}, // R8 hold
    {4'd2, 1'b0, 1'b1, 1'b0, 8'h33, 8'h33, 1'b0}, // R2
    {4'd6, 1'b1, 1'b1, 1'b1, 8'h01, 8'h00, 1'b0}, // R6 reader empty
    {4'd4, 1'b1, 1'b1, 1'b1, 8'h02, 8'h00, 1'b0}, // R4 high, no swap
    {4'd4, 1'b1, 1'b1, 1'b1, 8'h03, 8'h00, 1'b0}, // R4
    {4'd5, 1'b1, 1'b1, 1'b0, 8'h04, 8'h03, 1'b0}, // R5 swap edge
    {4'd4, 1'b1, 1'b1, 1'b0, 8'h05, 8'h02, 1'b0}, // R4 steady low
    {4'd4, 1'b1, 1'b1, 1'b1, 8'h06, 8'h01, 1'b0}, // R4 rising
    {4'd6, 1'b1, 1'b1, 1'b1, 8'h07, 8'h00, 1'b0}, // R6 past empty
    {4'd5, 1'b1, 1'b1, 1'b0, 8'h08, 8'h07, 1'b0}, // R5 swap
    {4'd8, 1'b1, 1'b0, 1'b1, 8'h99, 8'h07, 1'b0}, // R8 idle
    {4'd3, 1'b1, 1'b1, 1'b1, 8'h09, 8'h06, 1'b0}, // R3
    {4'd3, 1'b1, 1'b1, 1'b1, 8'h0A, 8'h05, 1'b0}, // R3
    {4'd3, 1'b1, 1'b1, 1'b1, 8'h0B, 8'h04, 1'b0}, // R3 writer now full
    {4'd7, 1'b1, 1'b1, 1'b1, 8'h0C, 8'h00, 1'b1}, // R7 dropped
    {4'd7, 1'b1, 1'b1, 1'b0, 8'h0D, 8'h0B, 1'b1}, // R7 sticky, intact
    {4'd7, 1'b1, 1'b1, 1'b0, 8'h0E, 8'h0A, 1'b1}, // R7
    {4'd9, 1'b0, 1'b1, 1'b1, 8'h55, 8'h55, 1'b1}, // R9 bypass
    {4'd9, 1'b0, 1'b1, 1'b0, 8'h66, 8'h66, 1'b1}, // R9 fall while off
    {4'd9, 1'b1, 1'b1, 1'b0, 8'h0F, 8'h09, 1'b1}  // R9 same reader
  };

  task automatic chk(input int tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rev_en = 1'b0; din_vld = 1'b0; xfer = 1'b0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(1, "reset dout", dout, 8'h00); // R1
    chk(1, "reset ovf", {7'd0, ovf}, 8'h00); // R1
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NV; i++) begin
      rev_en  = VEC[i][19];
      din_vld = VEC[i][18];
      xfer    = VEC[i][17];
      din     = VEC[i][16:9];
      @(posedge clk);
      #1;
      chk(int'(VEC[i][23:20]), "dout", dout, VEC[i][8:1]);
      chk(int'(VEC[i][23:20]), "ovf", {7'd0, ovf}, {7'd0, VEC[i][0]});
    end
    // R1: asynchronous reset mid-run clears output, flag and stacks
    rst_n = 1'b0;
    #2;
    chk(1, "async reset dout", dout, 8'h00);
    chk(1, "async reset ovf", {7'd0, ovf}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1; rev_en = 1'b1; din_vld = 1'b0; xfer = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    din_vld = 1'b1; din = 8'h77;
    @(posedge clk);
    #1;
    chk(1, "stacks empty after reset", dout, 8'h00); // R1 R6
    chk(1, "ovf after reset", {7'd0, ovf}, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule